// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns a 32-bit CPU address into one of eight chip-select lines for an external memory bus. Each of the eight banks owns one configuration word. The word holds a region base aligned to 128 KB, a compare mask that sets the region size as a power of two, and an enable bit. A small register port writes and reads these words, along with five timing words per bank. The timing words are kept as storage only.

On a valid address, every bank compares the upper address bits against its base, restricted to the bit positions its mask selects. The lowest-numbered bank that matches wins. One clock later the block asserts exactly one chip select, or raises a miss flag when no bank matches.

The first two banks behave differently from the rest. They decode even when their enable bit is clear, so an all-zero word in either one captures the whole bus space. Software parks them by writing all ones, which limits them to the topmost 128 KB. A boot-swap strap is captured while reset is held. When it is set, the chip selects of banks 0 and 1 are exchanged, and bank 0's enable bit reads back 0 after reset.

Top module: `csb_decoder`

## Requirements
- R1: After reset, the bank 0 word reads `{31'b0, ~strap}`, the words of banks 1 to 7 read 0, and every timing word reads 0.
- R2: Bank n's word is at byte offset 0x100+0x10·n. Its timing words are at 0x200+0x10·n, 0x204+0x10·n, 0x208+0x10·n, 0x20C+0x10·n and 0x300+0x10·n. A write to any of these offsets reads back unchanged. Reads of other offsets return 0, and writes to them change nothing.
- R3: Word bits 31:17 are the base and bits 15:1 are the mask. Address bit k (17..31) must equal base bit k whenever mask bit k−16 is 1. Address bits whose mask bit is 0 are ignored.
- R4: Banks 2 to 7 match only when bit 0 (enable) of their word is 1.
- R5: Banks 0 and 1 match regardless of bit 0. An all-zero word in either bank matches every address.
- R6: A word of 0xFFFFFFFF in bank 0 or 1 matches only addresses 0xFFFE0000 to 0xFFFFFFFF.
- R7: When several banks match, the bank with the lowest index wins.
- R8: If the strap is 1 while reset is held, bank 0 drives chip_sel[1] and bank 1 drives chip_sel[0]. Banks 2 to 7 always drive chip_sel[n]. Changes on the strap after reset have no effect.
- R9: chip_sel and bus_miss update one clock after a cycle with cpu_addr_valid high. After a cycle with cpu_addr_valid low, both are 0.
- R10: After a valid address, at most one chip_sel bit is 1, and bus_miss is 1 exactly when no bank matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_swap_strap | input | 1 | Strap captured while reset is held; exchanges chip selects 0 and 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cpu_addr | input | 32 | CPU address to decode |
| cpu_addr_valid | input | 1 | Qualifies cpu_addr |
| chip_sel | output | 8 | Registered one-hot chip selects |
| bus_miss | output | 1 | Registered no-match flag |

## Verification
Two functions can act in the same cycle: a register write and an address lookup. The bench provokes this by rewriting a bank word in the same clock that presents an address hitting that bank. The result must follow the old word, because the new word only takes effect after the edge. The swap mapping and the priority rule also apply together when banks 0 and 1 both match under a set strap. The bench judges both cases against a shadow model of the words and the captured strap.

// File: rtl/csb_pkg.sv
package csb_pkg;
    localparam int unsigned NUM_BANKS  = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned REG_AW     = 12;
    localparam int unsigned GRAIN_LSB  = 17;
    localparam int unsigned TIM_PER_BK = 5;
    localparam int unsigned BANK_OFS   = 'h100;
    localparam int unsigned TIM_LO_OFS = 'h200;
    localparam int unsigned TIM_HI_OFS = 'h300;
    localparam int unsigned BANK_STEP  = 'h10;

    // byte offset of timing word j of bank n
    function automatic int unsigned tim_offset(input int unsigned n, input int unsigned j);
        if (j < 4) return TIM_LO_OFS + BANK_STEP * n + 4 * j;
        return TIM_HI_OFS + BANK_STEP * n;
    endfunction
endpackage

// File: rtl/csb_regfile.sv
module csb_regfile
    import csb_pkg::*;
#(
    parameter int unsigned NB = NUM_BANKS,
    parameter int unsigned DW = WORD_W,
    parameter int unsigned AW = REG_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_i,
    input  logic                  wr_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output logic [NB-1:0][DW-1:0] bank_cfg_o,
    output logic                  swap_o
);
    logic [NB-1:0][DW-1:0]                 bank_q;
    logic [NB-1:0][TIM_PER_BK-1:0][DW-1:0] tim_q;
    logic [NB-1:0]                         bank_hit;
    logic [NB-1:0][TIM_PER_BK-1:0]         tim_hit;
    logic                                  swap_q;

    for (genvar n = 0; n < NB; n++) begin : g_bank
        localparam logic [AW-1:0] OFS = AW'(BANK_OFS + BANK_STEP * n);
        assign bank_hit[n] = (addr_i == OFS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                if (n == 0) bank_q[n] <= {{(DW-1){1'b0}}, ~strap_i};
                else        bank_q[n] <= '0;
            end else if (wr_i && bank_hit[n]) begin
                bank_q[n] <= wdata_i;
            end
        end

        for (genvar j = 0; j < TIM_PER_BK; j++) begin : g_tim
            localparam logic [AW-1:0] TOFS = AW'(tim_offset(n, j));
            assign tim_hit[n][j] = (addr_i == TOFS);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      tim_q[n][j] <= '0;
                else if (wr_i && tim_hit[n][j])  tim_q[n][j] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) swap_q <= strap_i;
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NB; n++) begin
            if (bank_hit[n]) rdata_o = rdata_o | bank_q[n];
            for (int j = 0; j < TIM_PER_BK; j++)
                if (tim_hit[n][j]) rdata_o = rdata_o | tim_q[n][j];
        end
    end

    assign bank_cfg_o = bank_q;
    assign swap_o     = swap_q;

    // R2: a write to bank word 0 shows up on the next cycle's configuration
    a_r2_bank0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == AW'(BANK_OFS)) |=> (bank_cfg_o[0] == $past(wdata_i)));
    // R8: the captured strap never changes outside reset
    a_r8_swap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(swap_o));
endmodule

// File: rtl/csb_bank_match.sv
module csb_bank_match
    import csb_pkg::*;
#(
    parameter int unsigned IDX = 0,
    parameter int unsigned DW  = WORD_W,
    parameter int unsigned LSB = GRAIN_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cfg_i,
    input  logic [DW-1:0] addr_i,
    output logic          hit_o
);
    localparam int unsigned FW = DW - LSB;

    logic [FW-1:0] base_f;
    logic [FW-1:0] mask_f;
    logic          en;
    logic          cmp_ok;

    assign base_f = cfg_i[DW-1:LSB];
    assign mask_f = cfg_i[FW:1];
    assign en     = cfg_i[0];
    assign cmp_ok = ((addr_i[DW-1:LSB] ^ base_f) & mask_f) == '0;

    if (IDX < 2) begin : g_always_on
        assign hit_o = cmp_ok;
    end else begin : g_gated
        assign hit_o = cmp_ok & en;
        // R4: a disabled upper bank never matches
        a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_i[0] |-> !hit_o);
    end
endmodule

// File: rtl/csb_select.sv
module csb_select
    import csb_pkg::*;
#(
    parameter int unsigned NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          swap_i,
    input  logic [NB-1:0] hit_i,
    output logic [NB-1:0] cs_o,
    output logic          miss_o
);
    localparam int unsigned IW = $clog2(NB);

    logic [IW-1:0] win_idx;
    logic [IW-1:0] phys_idx;
    logic          any_hit;
    logic [NB-1:0] cs_d;
    logic [NB-1:0] cs_q;
    logic          miss_q;

    always_comb begin
        win_idx = '0;
        for (int i = NB - 1; i >= 0; i--)
            if (hit_i[i]) win_idx = IW'(i);
    end

    assign any_hit  = |hit_i;
    assign phys_idx = (swap_i && win_idx < 2) ? (win_idx ^ IW'(1)) : win_idx;

    always_comb begin
        cs_d = '0;
        if (valid_i && any_hit) cs_d[phys_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '0;
            miss_q <= 1'b0;
        end else begin
            cs_q   <= cs_d;
            miss_q <= valid_i && !any_hit;
        end
    end

    assign cs_o   = cs_q;
    assign miss_o = miss_q;

    // R10: never more than one chip select
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));
    // R10: miss exactly when nothing is selected after a valid address
    a_r10_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (miss_o == (cs_o == '0)));
    // R9: idle cycle leaves outputs quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (cs_o == '0 && !miss_o));
    // R9: a matching valid address selects next cycle
    a_r9_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && any_hit) |=> (cs_o != '0));
endmodule

// File: rtl/csb_decoder.sv
module csb_decoder
    import csb_pkg::*;
#(
    parameter int unsigned NB = NUM_BANKS,
    parameter int unsigned DW = WORD_W,
    parameter int unsigned AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_swap_strap,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] cpu_addr,
    input  logic          cpu_addr_valid,
    output logic [NB-1:0] chip_sel,
    output logic          bus_miss
);
    logic [NB-1:0][DW-1:0] bank_cfg;
    logic [NB-1:0]         bank_hit;
    logic                  swap;

    csb_regfile #(.NB(NB), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (boot_swap_strap),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .bank_cfg_o (bank_cfg),
        .swap_o     (swap)
    );

    for (genvar n = 0; n < NB; n++) begin : g_match
        csb_bank_match #(.IDX(n), .DW(DW), .LSB(GRAIN_LSB)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_i  (bank_cfg[n]),
            .addr_i (cpu_addr),
            .hit_o  (bank_hit[n])
        );
    end

    csb_select #(.NB(NB)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (cpu_addr_valid),
        .swap_i  (swap),
        .hit_i   (bank_hit),
        .cs_o    (chip_sel),
        .miss_o  (bus_miss)
    );
endmodule

// File: tb/csb_decoder_tb.sv
module csb_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic        cpu_valid = 1'b0;
    logic [7:0]  chip_sel;
    logic        bus_miss;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] sh_bank [8];
    logic [31:0] sh_tim  [8][5];
    logic        sh_swap;

    always #5 clk = ~clk;

    csb_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .boot_swap_strap(strap),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_addr(cpu_addr), .cpu_addr_valid(cpu_valid),
        .chip_sel(chip_sel), .bus_miss(bus_miss)
    );

    function automatic logic [11:0] tofs(int n, int j);
        if (j < 4) return 12'(32'h200 + 32'h10 * n + 4 * j);
        return 12'(32'h300 + 32'h10 * n);
    endfunction

    // expected {miss, cs}
    function automatic logic [8:0] model(logic [31:0] a);
        for (int i = 0; i < 8; i++) begin
            logic [14:0] m;
            logic ok;
            m  = sh_bank[i][15:1];
            ok = (((a[31:17] ^ sh_bank[i][31:17]) & m) == 15'd0) && (i < 2 || sh_bank[i][0]);
            if (ok) begin
                int p;
                p = (sh_swap && i < 2) ? 1 - i : i;
                return {1'b0, 8'(1 << p)};
            end
        end
        return {1'b1, 8'h00};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic s);
        @(negedge clk);
        strap = s; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sh_bank[i] = (i == 0) ? {31'b0, ~s} : 32'd0;
            for (int j = 0; j < 5; j++) sh_tim[i][j] = 32'd0;
        end
        sh_swap = s;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (a == 12'(32'h100 + 32'h10 * i)) sh_bank[i] = d;
            for (int j = 0; j < 5; j++) if (a == tofs(i, j)) sh_tim[i][j] = d;
        end
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic look(logic [31:0] a, string tag);
        logic [8:0] e;
        e = model(a);
        @(negedge clk);
        cpu_addr = a; cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        check({bus_miss, chip_sel} === e, tag, {23'd0, bus_miss, chip_sel}, {23'd0, e});
    endtask

    task automatic park01();
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h110, 32'hFFFF_FFFF);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset(1'b0);
        // R1 reset values
        rd(12'h100, 32'h1, "R1 bank0 reset strap0");
        for (int i = 1; i < 8; i++) rd(12'(32'h100 + 16 * i), 32'h0, "R1 bank reset");
        rd(tofs(3, 4), 32'h0, "R1 timing reset");
        // R5 zero/reset bank0 captures all addresses
        look(32'h1234_5678, "R5 bank0 reset catches all");
        look(32'hFFFF_0000, "R5 bank0 reset catches all high");
        // R2 readback and unmapped
        wr(tofs(5, 2), 32'hA5A5_0001);
        rd(tofs(5, 2), 32'hA5A5_0001, "R2 timing readback");
        wr(tofs(7, 4), 32'h0BAD_F00D);
        rd(tofs(7, 4), 32'h0BAD_F00D, "R2 timing hi readback");
        wr(12'h104, 32'hDEAD_BEEF);
        rd(12'h104, 32'h0, "R2 unmapped read zero");
        rd(12'h100, 32'h1, "R2 unmapped write no effect");
        // R6 parking
        park01();
        rd(12'h110, 32'hFFFF_FFFF, "R2 bank1 readback");
        look(32'hFFFE_0000, "R6 parked low edge");
        look(32'hFFFD_FFFF, "R6 parked below miss");
        // R3/R4 bank2 1MB at 0x4000_0000
        wr(12'h120, 32'h4000_FFF1);
        look(32'h400F_FFFC, "R3 bank2 in region");
        look(32'h4010_0000, "R3 bank2 past region");
        wr(12'h120, 32'h4000_FFF0);
        look(32'h4008_0000, "R4 bank2 disabled miss");
        // R7 priority
        wr(12'h120, 32'h4000_FFF1);
        wr(12'h130, 32'h4000_FFF1);
        look(32'h4000_0000, "R7 lower bank wins");
        // R5 bank1 with enable clear still decodes
        wr(12'h110, 32'h8000_FFF0);
        look(32'h8000_1000, "R5 bank1 enable ignored");
        // R9 idle quiet
        @(negedge clk); #1;
        check(chip_sel === 8'h0 && bus_miss === 1'b0, "R9 idle quiet", {23'd0, bus_miss, chip_sel}, 32'd0);
        // concurrent write + lookup: lookup uses old word
        begin
            logic [8:0] e;
            e = model(32'h4000_0000);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 12'h120; reg_wdata = 32'h0;
            cpu_addr = 32'h4000_0000; cpu_valid = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0; cpu_valid = 1'b0; sh_bank[2] = 32'h0;
            check({bus_miss, chip_sel} === e, "R9 lookup sees old word", {23'd0, bus_miss, chip_sel}, {23'd0, e});
        end
        look(32'h4000_0000, "R7 bank3 after bank2 cleared");

        // R8 swap
        do_reset(1'b1);
        rd(12'h100, 32'h0, "R1 bank0 reset strap1");
        look(32'h0000_0000, "R8 swapped bank0 on cs1");
        @(negedge clk); strap = 1'b0;
        look(32'h0100_0000, "R8 strap change ignored");
        wr(12'h100, 32'hFFFF_FFFF);
        look(32'h0200_0000, "R8 swapped bank1 on cs0");
        look(32'hFFFF_FFF0, "R8 R7 both match swap");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int unsigned act;
            act = $urandom_range(0, 9);
            if (act < 3) begin
                int bk, sz;
                logic [31:0] w;
                bk = $urandom_range(0, 7);
                sz = $urandom_range(0, 15);
                w  = $urandom & 32'hFFFE_0000;
                w[15:1] = 15'h7FFF << sz;
                w[0] = $urandom_range(0, 3) != 0;
                if (bk < 2 && $urandom_range(0, 1)) w = 32'hFFFF_FFFF;
                wr(12'(32'h100 + 16 * bk), w);
            end else if (act < 8) begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom_range(0, 1)) a = {sh_bank[$urandom_range(0, 7)][31:17], a[16:0]};
                look(a, "R3 R7 R10 random lookup");
            end else begin
                int bk, j;
                bk = $urandom_range(0, 7);
                j  = $urandom_range(0, 5);
                if (j == 5) rd(12'(32'h100 + 16 * bk), sh_bank[bk], "R2 random bank read");
                else begin
                    logic [31:0] d;
                    d = $urandom;
                    wr(tofs(bk, j), d);
                    rd(tofs(bk, j), d, "R2 random timing read");
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule